// File: doc/BRIEF.md
# SPI Register Command Slave

This block is the device side of a register-access channel carried over a four-wire SPI link. The host frames a transfer with chip select and sends 32-bit words, most significant bit first, in SPI mode 0. The slave reads MOSI on rising SCK and changes MISO after falling SCK. The first word of a command is a control header. The header names the operation, a 4-bit memory map, a 16-bit start register address and a register count. Then come the write data words, or the dummy words the host clocks during a read. The block runs the accesses against a small register bank. Each command is mirrored back on MISO one word later, so the host can match every returned word to the access that produced it.

SPI pins are sampled with the system clock through a synchronizer, so SCK must run several times slower than `clk`. A command of N registers takes N+2 words in both directions. Several commands can be packed into one chip-select period. Raising chip select part way through a command ends it. A header that fails its parity check raises an error output, and the rest of that chip-select period is ignored.

Top module: `spi_regcmd_slave`

## Requirements
- R1: Header fields: bit 31 = 0 marks a register command, bit 29 = 1 means write and 0 means read, bits 27..24 select the map and bits 23..8 give the first register address. A valid command writes the host data into, or reads back from, the selected registers.
- R2: MISO timing: in command word 0 MISO is all zeros. In word 1 it carries the header with bit 30 cleared. From word 2 on it carries either the write data received one word earlier or the read data. Bits go out MSB first and change only after falling SCK.
- R3: Bits 7..1 hold the register count minus one, so 1 to 128 registers are accessed. A command always spans count+2 words, and the next header starts right after it.
- R4: Bit 0 makes the header's total parity odd. A header with even parity drives `cmd_hdr_err` high, changes no register, returns zeros on MISO and causes the rest of that chip-select period to be ignored. The flag stays high until the next chip-select period starts.
- R5: After each access the address moves up by one, unless header bit 28 is set. With bit 28 set, every access in the command uses the start address.
- R6: The word the host sends after the last write data word is ignored. During a read, every host word after the header is ignored, even one that looks like a valid header.
- R7: Map m and address a exist only when m < NUM_MAPS and a < NUM_REGS. A write anywhere else changes nothing, and a read there returns zero.
- R8: The value the host puts in header bit 30 has no effect on execution. It reads back as 0 in the echo.
- R9: If chip select rises during a command, only the register words received in full before that point are committed. The next chip-select period starts with a header.
- R10: Commands sent back to back in one chip-select period each run in full.
- R11: After reset, MISO and `cmd_hdr_err` are 0 and every register reads 0.
- R12: A header with bit 31 = 1 and good parity is not run. The rest of the chip-select period returns zeros and `cmd_hdr_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| cmd_hdr_err | output | 1 | Header parity failure in the current or most recent chip-select period |

## Verification
The bench uses the default bank of 2 maps with 8 registers each and a 2-stage synchronizer. With a bank this small, a maximum-length command of 128 registers runs far past the last register. One transfer therefore covers implemented and unimplemented addresses, and a check right after it confirms the command framing ends on the correct word. Two maps make it possible to show that an out-of-range address in one map does not alias onto a register in the other.

// File: rtl/rcs_pkg.sv
// Package: shared widths, header layout and helpers for the SPI register
// command slave. Field widths are fixed by the wire protocol.
package rcs_pkg;
    localparam int WORD_W = 32;
    localparam int MAP_W  = 4;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 7;
    localparam int CNT_W  = LEN_W + 1;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {ST_HDR, ST_EXEC, ST_SKIP} eng_state_t;

    // Control header as it arrives, MSB first.
    typedef struct packed {
        logic              is_data;
        logic              dev_bad;
        logic              wr;
        logic              no_inc;
        logic [MAP_W-1:0]  map;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len_m1;
        logic              par;
    } ctl_hdr_t;

    // Odd parity holds when the XOR of all bits is one.
    function automatic logic parity_ok(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction
endpackage

// File: rtl/rcs_sync.sv
// Module: rcs_sync
// Brings the three SPI pins into the clk domain and reports SCK edges and
// the chip-select start. Assumes SCK is at least four times slower than clk.
module rcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_start,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sck_q;
    logic              cs_act_q;

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe  <= '0;
            cs_pipe   <= '1;
            mosi_pipe <= '0;
            sck_q     <= 1'b0;
            cs_act_q  <= 1'b0;
        end else begin
            sck_pipe[0]  <= sck_i;
            cs_pipe[0]   <= cs_n_i;
            mosi_pipe[0] <= mosi_i;
            for (int i = 1; i < STAGES; i++) begin
                sck_pipe[i]  <= sck_pipe[i-1];
                cs_pipe[i]   <= cs_pipe[i-1];
                mosi_pipe[i] <= mosi_pipe[i-1];
            end
            sck_q    <= sck_pipe[STAGES-1];
            cs_act_q <= ~cs_pipe[STAGES-1];
        end
    end

    // Edge and level decode of the synchronized pins.
    always_comb begin
        sck_rise = sck_pipe[STAGES-1] & ~sck_q;
        sck_fall = ~sck_pipe[STAGES-1] & sck_q;
        cs_act   = ~cs_pipe[STAGES-1];
        cs_start = cs_act & ~cs_act_q;
        mosi_s   = mosi_pipe[STAGES-1];
    end
endmodule

// File: rtl/rcs_regbank.sv
// Module: rcs_regbank
// Demonstration register bank: NUM_MAPS maps of NUM_REGS 32-bit registers.
// Combinational read, one write per clock. Addresses outside the bank
// read as zero and ignore writes.
module rcs_regbank
    import rcs_pkg::*;
#(
    parameter int NUM_MAPS = 2,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MAP_W-1:0]  map,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int ENTRIES = NUM_MAPS * NUM_REGS;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] regs [ENTRIES];

    // Range check and flat index of the addressed register.
    always_comb begin
        hit   = (32'(map) < 32'(NUM_MAPS)) && (32'(addr) < 32'(NUM_REGS));
        idx   = IDX_W'(32'(map) * 32'(NUM_REGS) + 32'(addr));
        rdata = hit ? regs[idx] : '0;
    end

    // Register storage with write only on an in-range address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) regs[e] <= '0;
        end else if (wr_en && hit) begin
            regs[idx] <= wdata;
        end
    end
endmodule

// File: rtl/rcs_engine.sv
// Module: rcs_engine
// Word assembly, header decode and command sequencing. It expects
// synchronized SCK edges and mode 0 timing. The read port must answer in the
// same cycle. Each response word is loaded on the falling SCK that follows
// the last bit of the previous word.
module rcs_engine
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    output logic              miso_o,
    output logic              hdr_err_o,
    output logic              reg_wr_en,
    output logic [MAP_W-1:0]  reg_map,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] next_tx;
    logic [WORD_W-1:0] rx_word;
    logic              word_done;
    logic              access;
    eng_state_t        st_q;
    logic              is_wr;
    logic              no_inc;
    logic [MAP_W-1:0]  map_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  words_left;
    logic              hdr_err_q;
    ctl_hdr_t          hdr;

    // Word completion and header view of the incoming word.
    always_comb begin
        rx_word   = {rx_sr[WORD_W-2:0], mosi_s};
        word_done = cs_act && sck_rise && (bit_cnt == BIT_W'(WORD_W - 1));
        hdr       = ctl_hdr_t'(rx_word);
        access    = word_done && (st_q == ST_EXEC) && (words_left != '0);
    end

    // Outputs to the register bank and the pins.
    always_comb begin
        reg_wr_en = access && is_wr;
        reg_map   = map_q;
        reg_addr  = addr_q;
        reg_wdata = rx_word;
        miso_o    = tx_sr[WORD_W-1];
        hdr_err_o = hdr_err_q;
    end

    // Receive shifter and bit counter, cleared while chip select is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            rx_sr   <= rx_word;
        end
    end

    // Command sequencer: decode headers, run accesses, choose the next reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_HDR;
            next_tx    <= '0;
            hdr_err_q  <= 1'b0;
            is_wr      <= 1'b0;
            no_inc     <= 1'b0;
            map_q      <= '0;
            addr_q     <= '0;
            words_left <= '0;
        end else if (!cs_act) begin
            st_q    <= ST_HDR;
            next_tx <= '0;
        end else begin
            if (cs_start) hdr_err_q <= 1'b0;
            if (word_done) begin
                unique case (st_q)
                    ST_HDR: begin
                        if (!parity_ok(rx_word)) begin
                            hdr_err_q <= 1'b1;
                            st_q      <= ST_SKIP;
                            next_tx   <= '0;
                        end else if (hdr.is_data) begin
                            st_q    <= ST_SKIP;
                            next_tx <= '0;
                        end else begin
                            is_wr      <= hdr.wr;
                            no_inc     <= hdr.no_inc;
                            map_q      <= hdr.map;
                            addr_q     <= hdr.addr;
                            words_left <= CNT_W'(hdr.len_m1) + 1'b1;
                            next_tx    <= {rx_word[WORD_W-1], 1'b0, rx_word[WORD_W-3:0]};
                            st_q       <= ST_EXEC;
                        end
                    end
                    ST_EXEC: begin
                        if (words_left != '0) begin
                            next_tx    <= is_wr ? rx_word : reg_rdata;
                            words_left <= words_left - 1'b1;
                            if (!no_inc) addr_q <= addr_q + 1'b1;
                        end else begin
                            st_q    <= ST_HDR;
                            next_tx <= '0;
                        end
                    end
                    default: next_tx <= '0;
                endcase
            end
        end
    end

    // Transmit shifter: load on the falling edge after a word, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (!cs_act) begin
            tx_sr <= '0;
        end else if (sck_fall) begin
            tx_sr <= (bit_cnt == '0) ? next_tx : {tx_sr[WORD_W-2:0], 1'b0};
        end
    end

    // R2: MISO moves only on a falling SCK while selected.
    assert_miso_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$past(sck_fall)) |-> $stable(miso_o));

    // R4: no register write while a bad header is being flagged.
    assert_no_write_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err_q |-> !reg_wr_en);

    // R4: a new chip-select period clears the error flag.
    assert_err_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> !hdr_err_o);

    // R3: remaining register count never exceeds the largest command.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        words_left <= CNT_W'(1 << LEN_W));

    // R5: each access steps the address by one, or by zero when disabled.
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> ((reg_addr - $past(reg_addr)) == ADDR_W'($past(no_inc) ? 0 : 1)));
endmodule

// File: rtl/spi_regcmd_slave.sv
// Module: spi_regcmd_slave
// Top level: SPI pin synchronizer, command engine and demonstration register
// bank. Assumes SPI mode 0 and an SCK well below the clk rate.
module spi_regcmd_slave
    import rcs_pkg::*;
#(
    parameter int NUM_MAPS    = 2,
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic cmd_hdr_err
);
    logic              sck_rise;
    logic              sck_fall;
    logic              cs_act;
    logic              cs_start;
    logic              mosi_s;
    logic              reg_wr_en;
    logic [MAP_W-1:0]  reg_map;
    logic [ADDR_W-1:0] reg_addr;
    logic [WORD_W-1:0] reg_wdata;
    logic [WORD_W-1:0] reg_rdata;

    rcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_sck),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_start (cs_start),
        .mosi_s   (mosi_s)
    );

    rcs_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .miso_o    (spi_miso),
        .hdr_err_o (cmd_hdr_err),
        .reg_wr_en (reg_wr_en),
        .reg_map   (reg_map),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    rcs_regbank #(.NUM_MAPS(NUM_MAPS), .NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .map   (reg_map),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata)
    );
endmodule

// File: tb/sim_spi_regcmd_slave.sv
// Directed bench for spi_regcmd_slave: an SPI mode 0 host model, a register
// model built from the requirements, and one task per scenario.
module sim_spi_regcmd_slave;
    localparam int NM   = 2;
    localparam int NR   = 8;
    localparam int HALF = 5;
    localparam int MAXW = 140;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic hdr_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [NM*NR];
    logic [31:0] txw [MAXW];
    logic [31:0] rxw [MAXW];

    always #10 clk = ~clk;

    spi_regcmd_slave #(.NUM_MAPS(NM), .NUM_REGS(NR), .SYNC_STAGES(2)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .cmd_hdr_err (hdr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(input bit wr, input bit aid, input int mm,
                                          input int ad, input int cnt, input bit b30);
        logic [31:0] h;
        h = {1'b0, b30, wr, aid, 4'(mm), 16'(ad), 7'(cnt - 1), 1'b0};
        h[0] = ~(^h[31:1]);
        return h;
    endfunction

    function automatic logic [31:0] echo(input logic [31:0] h);
        return h & 32'hBFFF_FFFF;
    endfunction

    function automatic logic [31:0] mdl_rd(input int mm, input int ad);
        if (mm < NM && ad < NR) return mdl[mm*NR + ad];
        return 32'h0;
    endfunction

    task automatic mdl_wr(input int mm, input int ad, input logic [31:0] v);
        if (mm < NM && ad < NR) mdl[mm*NR + ad] = v;
    endtask

    task automatic spi_word(input logic [31:0] tx, input int nb, output logic [31:0] rx);
        rx = '0;
        for (int b = 31; b > 31 - nb; b--) begin
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic run_words(input int n);
        for (int i = 0; i < n; i++) spi_word(txw[i], 32, rxw[i]);
    endtask

    // Write n registers in one chip-select period and check the echo.
    task automatic do_write(input int mm, input int ad, input bit aid, input int n,
                            input logic [31:0] base, input string tag);
        txw[0] = mkhdr(1'b1, aid, mm, ad, n, 1'b0);
        for (int k = 0; k < n; k++) txw[1+k] = base + 32'(k) * 32'h0101_0107;
        txw[n+1] = 32'hFFFF_FFFF;
        cs_begin(); run_words(n + 2); cs_end();
        chk({tag, " R2 lead word"}, rxw[0], 32'h0);
        chk({tag, " R2 header echo"}, rxw[1], echo(txw[0]));
        for (int k = 0; k < n; k++) begin
            chk({tag, " R2 write echo"}, rxw[2+k], txw[1+k]);
            mdl_wr(mm, aid ? ad : ad + k, txw[1+k]);
        end
    endtask

    // Read n registers; host words after the header look like writes (R6).
    task automatic do_read(input int mm, input int ad, input bit aid, input int n,
                           input string tag);
        txw[0] = mkhdr(1'b0, aid, mm, ad, n, 1'b0);
        for (int k = 1; k <= n + 1; k++) txw[k] = mkhdr(1'b1, 1'b0, mm, ad, 1, 1'b0);
        cs_begin(); run_words(n + 2); cs_end();
        chk({tag, " R2 lead word"}, rxw[0], 32'h0);
        chk({tag, " R2 header echo"}, rxw[1], echo(txw[0]));
        for (int k = 0; k < n; k++)
            chk({tag, " R1 read data"}, rxw[2+k], mdl_rd(mm, aid ? ad : ad + k));
    endtask

    task automatic t_reset();
        chk("R11 miso after reset", 32'(miso), 32'h0);
        chk("R11 error flag after reset", 32'(hdr_err), 32'h0);
        do_read(0, 0, 1'b0, NR, "R11 map0");
        do_read(1, 0, 1'b0, NR, "R11 map1");
    endtask

    task automatic t_write_read();
        do_write(1, 2, 1'b0, 3, 32'hA5A5_0001, "R1 wr");
        do_read(1, 1, 1'b0, 5, "R1 rd");
        do_write(0, 5, 1'b0, 1, 32'h1234_5678, "R1 wr single");
        do_read(0, 5, 1'b0, 1, "R1 rd single");
    endtask

    task automatic t_no_inc();
        do_write(0, 3, 1'b1, 3, 32'h0BAD_F00D, "R5 aid wr");
        do_read(0, 2, 1'b0, 3, "R5 neighbours");
        do_read(0, 3, 1'b1, 3, "R5 aid rd");
    endtask

    task automatic t_ignored_words();
        do_read(0, 0, 1'b0, 2, "R6 junk during read");
        do_read(0, 0, 1'b0, NR, "R6 after read");
        do_read(1, 1, 1'b0, 1, "R6 after read map1");
    endtask

    task automatic t_unimpl();
        do_write(3, 0, 1'b0, 1, 32'hDEAD_0003, "R7 bad map wr");
        do_write(0, NR + 1, 1'b0, 1, 32'hDEAD_0009, "R7 bad addr wr");
        do_read(3, 0, 1'b0, 1, "R7 bad map rd");
        do_read(0, NR + 1, 1'b0, 1, "R7 bad addr rd");
        do_read(1, 0, 1'b0, NR, "R7 no alias map1");
        do_read(0, 0, 1'b0, NR, "R7 map0 intact");
    endtask

    task automatic t_bit30();
        txw[0] = mkhdr(1'b1, 1'b0, 1, 0, 1, 1'b1);
        txw[1] = 32'h3030_3030;
        txw[2] = 32'h0;
        cs_begin(); run_words(3); cs_end();
        chk("R8 echo shows bit 30 clear", rxw[1], echo(txw[0]));
        chk("R8 error flag untouched", 32'(hdr_err), 32'h0);
        mdl_wr(1, 0, txw[1]);
        do_read(1, 0, 1'b0, 1, "R8 command executed");
    endtask

    task automatic t_parity();
        logic [31:0] any;
        txw[0] = mkhdr(1'b1, 1'b0, 0, 1, 1, 1'b0) ^ 32'h1;
        txw[1] = 32'h5555_AAAA;
        txw[2] = 32'h0;
        txw[3] = mkhdr(1'b1, 1'b0, 0, 1, 1, 1'b0);
        txw[4] = 32'h6666_9999;
        txw[5] = 32'h0;
        cs_begin(); run_words(6);
        chk("R4 error flag raised", 32'(hdr_err), 32'h1);
        cs_end();
        any = '0;
        for (int i = 0; i < 6; i++) any = any | rxw[i];
        chk("R4 MISO zeros after bad header", any, 32'h0);
        chk("R4 error flag held after deselect", 32'(hdr_err), 32'h1);
        cs_begin();
        chk("R4 error flag cleared by new period", 32'(hdr_err), 32'h0);
        cs_end();
        do_read(0, 0, 1'b0, 3, "R4 no register changed");
    endtask

    task automatic t_data_hdr();
        logic [31:0] any;
        txw[0] = {1'b1, 31'h0020_0000};
        txw[0][0] = ~(^txw[0][31:1]);
        txw[1] = mkhdr(1'b1, 1'b0, 0, 2, 1, 1'b0);
        txw[2] = 32'h7777_7777;
        txw[3] = 32'h0;
        cs_begin(); run_words(4); cs_end();
        any = '0;
        for (int i = 0; i < 4; i++) any = any | rxw[i];
        chk("R12 MISO zeros for data header", any, 32'h0);
        chk("R12 no error flag", 32'(hdr_err), 32'h0);
        do_read(0, 2, 1'b0, 1, "R12 register unchanged");
    endtask

    task automatic t_back_to_back();
        txw[0] = mkhdr(1'b1, 1'b0, 1, 6, 1, 1'b0);
        txw[1] = 32'hB2B0_0006;
        txw[2] = 32'hFFFF_FFFF;
        txw[3] = mkhdr(1'b0, 1'b0, 1, 6, 1, 1'b0);
        txw[4] = 32'h0;
        txw[5] = 32'h0;
        cs_begin(); run_words(6); cs_end();
        mdl_wr(1, 6, txw[1]);
        chk("R10 write echo", rxw[2], txw[1]);
        chk("R10 second lead word", rxw[3], 32'h0);
        chk("R10 second header echo", rxw[4], echo(txw[3]));
        chk("R10 read in same period", rxw[5], mdl_rd(1, 6));
    endtask

    task automatic t_abort();
        logic [31:0] dummy;
        txw[0] = mkhdr(1'b1, 1'b0, 1, 4, 4, 1'b0);
        txw[1] = 32'hAB00_0004;
        txw[2] = 32'hAB00_0005;
        txw[3] = 32'hAB00_0006;
        cs_begin();
        spi_word(txw[0], 32, dummy);
        spi_word(txw[1], 32, dummy);
        spi_word(txw[2], 32, dummy);
        spi_word(txw[3], 16, dummy);
        cs_end();
        mdl_wr(1, 4, txw[1]);
        mdl_wr(1, 5, txw[2]);
        do_read(1, 4, 1'b0, 4, "R9 abort keeps full words only");
    endtask

    task automatic t_max_len();
        int n;
        do_write(0, 0, 1'b0, 128, 32'h4000_0000, "R3 max wr");
        n = 130;
        txw[0] = mkhdr(1'b0, 1'b0, 0, 0, 128, 1'b0);
        for (int k = 1; k < n; k++) txw[k] = 32'h0;
        txw[n]   = mkhdr(1'b0, 1'b0, 1, 5, 1, 1'b0);
        txw[n+1] = 32'h0;
        txw[n+2] = 32'h0;
        cs_begin(); run_words(n + 3); cs_end();
        chk("R3 max rd header echo", rxw[1], echo(txw[0]));
        for (int k = 0; k < 128; k++)
            chk("R3 max rd data", rxw[2+k], mdl_rd(0, k));
        chk("R3 next header after 130 words", rxw[n+1], echo(txw[n]));
        chk("R3 next command data", rxw[n+2], mdl_rd(1, 5));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NM*NR; i++) mdl[i] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_no_inc();
        t_ignored_words();
        t_unimpl();
        t_bit30();
        t_parity();
        t_data_hdr();
        t_back_to_back();
        t_abort();
        t_max_len();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule